// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

This block sits right after a pair of parallel decoders. In every cycle it looks at the two oldest decoded instructions, in program order, and issues them to two integer lanes. The primary lane accepts any instruction. The secondary lane accepts only a plain instruction that needs no shifter, and only when that instruction does not depend on its older neighbour. If the younger instruction does not qualify, only the older one goes out, and the secondary lane carries a bubble.

The block tells the instruction queue upstream how many entries it took: none, one or two. It also holds a short chain of lane registers for the stages behind the issue point (decode-1, decode-2, execute, writeback). Both lanes advance through this chain together. A single downstream stall freezes the issue point and every stage of the chain at once.

Top module: `dual_issue_pair`

## Requirements
- R1: When slot 0 is not valid, nothing issues: both issue valids are 0 and `issue_cnt` is 0. This holds even when slot 1 is valid.
- R2: When slot 0 is valid and slot 1 is not, only the primary lane issues, carrying slot 0's payload, and `issue_cnt` is 1.
- R3: When slot 1 has its simple flag at 0, it is not paired. Only slot 0 issues and `issue_cnt` is 1.
- R4: When slot 1 has its shift flag at 1, it never issues to the secondary lane, even if its simple flag is 1.
- R5: When slot 0 writes register d (`s0_dst_we`=1) and slot 1 reads d through source A or source B with that source's use flag at 1, pairing is blocked. A matching index whose use flag is 0 does not block pairing.
- R6: When both slots write the same destination index, pairing is blocked. When `s0_dst_we` is 0, slot 0 causes no conflict of any kind.
- R7: When none of the conditions above applies, both lanes issue in the same cycle. The primary lane carries slot 0's payload, the secondary lane carries slot 1's payload, and `issue_cnt` is 2.
- R8: While `stall` is 1, `issue_cnt` is 0, both issue valids are 0, and every stage of the chain holds its valid bits and payloads.
- R9: Each clock edge without a stall moves a lane pair one stage deeper. An instruction issued in cycle c appears in stage k (0 = decode-1, NSTAGE-1 = writeback) after k+1 unstalled edges, with both lanes side by side. A bubble in the secondary lane travels in step as a valid bit of 0.
- R10: A synchronous reset (`rst_n`=0 at a clock edge) clears every stage valid bit in both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Downstream stall; freezes issue and the chain |
| s0_valid | input | 1 | Slot 0 (older) holds an instruction |
| s0_simple | input | 1 | Slot 0 simple-class flag |
| s0_shift | input | 1 | Slot 0 shift-class flag |
| s0_dst_we | input | 1 | Slot 0 writes a register |
| s0_dst | input | REG_W | Slot 0 destination index |
| s0_srca_use | input | 1 | Slot 0 reads source A |
| s0_srca | input | REG_W | Slot 0 source A index |
| s0_srcb_use | input | 1 | Slot 0 reads source B |
| s0_srcb | input | REG_W | Slot 0 source B index |
| s0_payload | input | PAY_W | Slot 0 opaque payload |
| s1_valid | input | 1 | Slot 1 (younger) holds an instruction |
| s1_simple | input | 1 | Slot 1 simple-class flag |
| s1_shift | input | 1 | Slot 1 shift-class flag |
| s1_dst_we | input | 1 | Slot 1 writes a register |
| s1_dst | input | REG_W | Slot 1 destination index |
| s1_srca_use | input | 1 | Slot 1 reads source A |
| s1_srca | input | REG_W | Slot 1 source A index |
| s1_srcb_use | input | 1 | Slot 1 reads source B |
| s1_srcb | input | REG_W | Slot 1 source B index |
| s1_payload | input | PAY_W | Slot 1 opaque payload |
| issue_cnt | output | 2 | Instructions consumed this cycle (0, 1, 2) |
| iss_u_valid | output | 1 | Primary lane issue valid |
| iss_u_payload | output | PAY_W | Primary lane issue payload |
| iss_v_valid | output | 1 | Secondary lane issue valid |
| iss_v_payload | output | PAY_W | Secondary lane issue payload |
| stg_u_valid | output | NSTAGE | Primary lane valid bit per stage (bit 0 = decode-1) |
| stg_v_valid | output | NSTAGE | Secondary lane valid bit per stage |
| wb_u_payload | output | PAY_W | Primary lane payload in the last stage |
| wb_v_payload | output | PAY_W | Secondary lane payload in the last stage |

## Verification
The pairing decision is tried with one pattern per blocking cause: an empty older slot, an empty younger slot, a non-simple younger instruction, a shift instruction that is marked simple, a read-after-write hit on each source port, and a write-after-write hit. It is also tried with near-miss patterns in which the index matches but the use flag or the write enable is 0. These show that each condition blocks pairing on its own, and that only a real dependency does so. The chain is driven with a full pair, a single issue with a bubble, a stall held for several cycles, and a reset in the middle of a run. Together these separate correct lockstep movement from lanes that drift apart, stages that move during a stall, and stale valid bits left after reset.

// File: rtl/pair_pkg.sv
`timescale 1ns/1ps
// Package pair_pkg
// Shared widths and types for the dual-issue pairing unit.
// Assumes: register indices and payloads are plain bit vectors.
package pair_pkg;
    parameter int unsigned REG_W = 5;
    parameter int unsigned PAY_W = 16;

    // One lane slot as it moves through the stage chain
    typedef struct packed {
        logic             valid;
        logic [PAY_W-1:0] payload;
    } lane_t;

    // How many queue entries the issue point took this cycle
    typedef enum logic [1:0] {
        CNT_NONE = 2'd0,
        CNT_ONE  = 2'd1,
        CNT_TWO  = 2'd2
    } issue_cnt_e;
endpackage

// File: rtl/pair_dep_check.sv
`timescale 1ns/1ps
// Module pair_dep_check
// Finds register dependencies of the younger slot on the older slot.
// raw_hit: the younger reads a register that the older writes.
// waw_hit: both write the same register.
// Assumes: an index is only meaningful when its use or write-enable flag is set.
module pair_dep_check
    import pair_pkg::*;
(
    input  logic             old_we,
    input  logic [REG_W-1:0] old_dst,
    input  logic             yng_we,
    input  logic [REG_W-1:0] yng_dst,
    input  logic             yng_srca_use,
    input  logic [REG_W-1:0] yng_srca,
    input  logic             yng_srcb_use,
    input  logic [REG_W-1:0] yng_srcb,
    output logic             raw_hit,
    output logic             waw_hit
);
    logic hit_a;
    logic hit_b;

    // Compare each younger source against the older destination
    always_comb begin
        hit_a   = yng_srca_use && (yng_srca == old_dst);
        hit_b   = yng_srcb_use && (yng_srcb == old_dst);
        raw_hit = old_we && (hit_a || hit_b);
    end

    // Compare the two destinations
    always_comb begin
        waw_hit = old_we && yng_we && (yng_dst == old_dst);
    end
endmodule

// File: rtl/pair_issue_sel.sv
`timescale 1ns/1ps
// Module pair_issue_sel
// Chooses single or dual issue and drives both lane entries and the count.
// Assumes: slot 1 is the instruction right after slot 0 in program order,
// and the dependency flags come from pair_dep_check.
module pair_issue_sel
    import pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             s0_valid,
    input  logic [PAY_W-1:0] s0_payload,
    input  logic             s1_valid,
    input  logic             s1_simple,
    input  logic             s1_shift,
    input  logic [PAY_W-1:0] s1_payload,
    input  logic             raw_hit,
    input  logic             waw_hit,
    output lane_t            u_lane,
    output lane_t            v_lane,
    output issue_cnt_e       cnt
);
    logic v_fit;
    logic pair_ok;

    // Check whether slot 1 is allowed in the secondary lane
    always_comb begin
        v_fit   = s1_valid && s1_simple && !s1_shift;
        pair_ok = s0_valid && v_fit && !raw_hit && !waw_hit;
    end

    // Fill the lane entries; a stall turns both into bubbles
    always_comb begin
        u_lane.valid   = s0_valid && !stall;
        u_lane.payload = s0_payload;
        v_lane.valid   = pair_ok && !stall;
        v_lane.payload = s1_payload;
    end

    // Report how many entries were consumed
    always_comb begin
        if (stall || !s0_valid) cnt = CNT_NONE;
        else if (pair_ok)       cnt = CNT_TWO;
        else                    cnt = CNT_ONE;
    end

    // R7
    v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_lane.valid |-> u_lane.valid);
    // R4
    no_shift_in_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_lane.valid |-> (s1_simple && !s1_shift));
    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (cnt == CNT_NONE && !u_lane.valid && !v_lane.valid));
    // R1
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({u_lane.valid, v_lane.valid}) == int'(cnt));
endmodule

// File: rtl/pair_lockstep_chain.sv
`timescale 1ns/1ps
// Module pair_lockstep_chain
// NSTAGE lane-pair registers behind the issue point. All stages advance
// together, or all hold together, so a pair never splits.
// Assumes: advance is low for the whole chain while downstream stalls.
module pair_lockstep_chain
    import pair_pkg::*;
#(
    parameter int unsigned NSTAGE = 4
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  lane_t             u_in,
    input  lane_t             v_in,
    output logic [NSTAGE-1:0] u_vld,
    output logic [NSTAGE-1:0] v_vld,
    output lane_t             u_last,
    output lane_t             v_last
);
    localparam int unsigned LAST = NSTAGE - 1;

    lane_t [NSTAGE-1:0] u_stg;
    lane_t [NSTAGE-1:0] v_stg;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        lane_t u_src;
        lane_t v_src;

        if (k == 0) begin : g_head
            assign u_src = u_in;
            assign v_src = v_in;
        end else begin : g_body
            assign u_src = u_stg[k-1];
            assign v_src = v_stg[k-1];
        end

        // Stage register: clear on reset, load on advance, else hold
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                u_stg[k] <= '0;
                v_stg[k] <= '0;
            end else if (advance) begin
                u_stg[k] <= u_src;
                v_stg[k] <= v_src;
            end
        end

        assign u_vld[k] = u_stg[k].valid;
        assign v_vld[k] = v_stg[k].valid;

        // R8
        stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !advance |=> ($stable(u_stg[k]) && $stable(v_stg[k])));
        // R9
        lockstep_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            v_stg[k].valid |-> u_stg[k].valid);
    end

    assign u_last = u_stg[LAST];
    assign v_last = v_stg[LAST];
endmodule

// File: rtl/dual_issue_pair.sv
`timescale 1ns/1ps
// Module dual_issue_pair
// Top of the pairing unit: dependency check, issue selection, lockstep chain.
// Assumes: slot 0 is older than slot 1, and the upstream queue advances
// by issue_cnt each cycle.
module dual_issue_pair
    import pair_pkg::*;
#(
    parameter int unsigned NSTAGE = 4
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stall,
    input  logic                       s0_valid,
    input  logic                       s0_simple,
    input  logic                       s0_shift,
    input  logic                       s0_dst_we,
    input  logic [pair_pkg::REG_W-1:0] s0_dst,
    input  logic                       s0_srca_use,
    input  logic [pair_pkg::REG_W-1:0] s0_srca,
    input  logic                       s0_srcb_use,
    input  logic [pair_pkg::REG_W-1:0] s0_srcb,
    input  logic [pair_pkg::PAY_W-1:0] s0_payload,
    input  logic                       s1_valid,
    input  logic                       s1_simple,
    input  logic                       s1_shift,
    input  logic                       s1_dst_we,
    input  logic [pair_pkg::REG_W-1:0] s1_dst,
    input  logic                       s1_srca_use,
    input  logic [pair_pkg::REG_W-1:0] s1_srca,
    input  logic                       s1_srcb_use,
    input  logic [pair_pkg::REG_W-1:0] s1_srcb,
    input  logic [pair_pkg::PAY_W-1:0] s1_payload,
    output logic [1:0]                 issue_cnt,
    output logic                       iss_u_valid,
    output logic [pair_pkg::PAY_W-1:0] iss_u_payload,
    output logic                       iss_v_valid,
    output logic [pair_pkg::PAY_W-1:0] iss_v_payload,
    output logic [NSTAGE-1:0]          stg_u_valid,
    output logic [NSTAGE-1:0]          stg_v_valid,
    output logic [pair_pkg::PAY_W-1:0] wb_u_payload,
    output logic [pair_pkg::PAY_W-1:0] wb_v_payload
);
    logic       raw_hit;
    logic       waw_hit;
    lane_t      u_lane;
    lane_t      v_lane;
    lane_t      u_last;
    lane_t      v_last;
    issue_cnt_e cnt;

    // Slot 0 source fields belong to older instructions' hazards, not this pair
    logic unused_s0;
    assign unused_s0 = ^{s0_simple, s0_shift, s0_srca_use, s0_srca,
                         s0_srcb_use, s0_srcb};

    pair_dep_check u_dep (
        .old_we       (s0_dst_we),
        .old_dst      (s0_dst),
        .yng_we       (s1_dst_we),
        .yng_dst      (s1_dst),
        .yng_srca_use (s1_srca_use),
        .yng_srca     (s1_srca),
        .yng_srcb_use (s1_srcb_use),
        .yng_srcb     (s1_srcb),
        .raw_hit      (raw_hit),
        .waw_hit      (waw_hit)
    );

    pair_issue_sel u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall      (stall),
        .s0_valid   (s0_valid),
        .s0_payload (s0_payload),
        .s1_valid   (s1_valid),
        .s1_simple  (s1_simple),
        .s1_shift   (s1_shift),
        .s1_payload (s1_payload),
        .raw_hit    (raw_hit),
        .waw_hit    (waw_hit),
        .u_lane     (u_lane),
        .v_lane     (v_lane),
        .cnt        (cnt)
    );

    pair_lockstep_chain #(.NSTAGE(NSTAGE)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (!stall),
        .u_in    (u_lane),
        .v_in    (v_lane),
        .u_vld   (stg_u_valid),
        .v_vld   (stg_v_valid),
        .u_last  (u_last),
        .v_last  (v_last)
    );

    // Drive the issue-point and last-stage outputs
    always_comb begin
        issue_cnt     = cnt;
        iss_u_valid   = u_lane.valid;
        iss_u_payload = u_lane.payload;
        iss_v_valid   = v_lane.valid;
        iss_v_payload = v_lane.payload;
        wb_u_payload  = u_last.payload;
        wb_v_payload  = v_last.payload;
    end

    // R5
    raw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_v_valid |-> !(s0_dst_we &&
            ((s1_srca_use && s1_srca == s0_dst) ||
             (s1_srcb_use && s1_srcb == s0_dst))));
    // R6
    waw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_v_valid |-> !(s0_dst_we && s1_dst_we && s1_dst == s0_dst));
endmodule

// File: tb/dual_issue_pair_test.sv
`timescale 1ns/1ps
module dual_issue_pair_test;
    localparam int NST = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stall;
    logic s0_valid, s0_simple, s0_shift, s0_dst_we, s0_srca_use, s0_srcb_use;
    logic [4:0] s0_dst, s0_srca, s0_srcb;
    logic [15:0] s0_payload;
    logic s1_valid, s1_simple, s1_shift, s1_dst_we, s1_srca_use, s1_srcb_use;
    logic [4:0] s1_dst, s1_srca, s1_srcb;
    logic [15:0] s1_payload;
    logic [1:0] issue_cnt;
    logic iss_u_valid, iss_v_valid;
    logic [15:0] iss_u_payload, iss_v_payload, wb_u_payload, wb_v_payload;
    logic [NST-1:0] stg_u_valid, stg_v_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_issue_pair #(.NSTAGE(NST)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        stall = 0;
        {s0_valid, s0_simple, s0_shift, s0_dst_we, s0_srca_use, s0_srcb_use} = '0;
        {s1_valid, s1_simple, s1_shift, s1_dst_we, s1_srca_use, s1_srcb_use} = '0;
        s0_dst = 0; s0_srca = 0; s0_srcb = 0; s0_payload = 0;
        s1_dst = 0; s1_srca = 0; s1_srcb = 0; s1_payload = 0;
    endtask

    // Two independent simple instructions that should pair
    task automatic base_pair();
        idle();
        s0_valid = 1; s0_dst_we = 1; s0_dst = 3; s0_srca = 1; s0_srcb = 2;
        s0_srca_use = 1; s0_srcb_use = 1; s0_payload = 16'hA0A0;
        s1_valid = 1; s1_simple = 1; s1_dst_we = 1; s1_dst = 5;
        s1_srca = 6; s1_srcb = 7; s1_srca_use = 1; s1_srcb_use = 1;
        s1_payload = 16'hB1B1;
    endtask

    task automatic expect_issue(input string req, input int cnt, input bit u, input bit v);
        #1;
        chk(req, issue_cnt, cnt);
        chk(req, iss_u_valid, u);
        chk(req, iss_v_valid, v);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        idle();
        repeat (2) step();
        chk("R10", stg_u_valid, 0);
        chk("R10", stg_v_valid, 0);
        rst_n = 1;
    endtask

    task automatic t_slot0_empty();
        @(negedge clk); base_pair(); s0_valid = 0;
        expect_issue("R1", 0, 0, 0);
    endtask

    task automatic t_slot1_empty();
        @(negedge clk); base_pair(); s1_valid = 0;
        expect_issue("R2", 1, 1, 0);
        chk("R2", iss_u_payload, 16'hA0A0);
    endtask

    task automatic t_not_simple();
        @(negedge clk); base_pair(); s1_simple = 0;
        expect_issue("R3", 1, 1, 0);
    endtask

    task automatic t_shift();
        @(negedge clk); base_pair(); s1_shift = 1;
        expect_issue("R4", 1, 1, 0);
    endtask

    task automatic t_raw();
        @(negedge clk); base_pair(); s1_srca = 3;
        expect_issue("R5 srcA", 1, 1, 0);
        @(negedge clk); base_pair(); s1_srcb = 3;
        expect_issue("R5 srcB", 1, 1, 0);
        @(negedge clk); base_pair(); s1_srcb = 3; s1_srcb_use = 0;
        expect_issue("R5 unused src", 2, 1, 1);
    endtask

    task automatic t_waw();
        @(negedge clk); base_pair(); s1_dst = 3;
        expect_issue("R6 same dst", 1, 1, 0);
        @(negedge clk); base_pair(); s1_dst = 3; s1_srca = 3; s0_dst_we = 0;
        expect_issue("R6 older no write", 2, 1, 1);
    endtask

    task automatic t_pair();
        @(negedge clk); base_pair();
        expect_issue("R7", 2, 1, 1);
        chk("R7", iss_u_payload, 16'hA0A0);
        chk("R7", iss_v_payload, 16'hB1B1);
    endtask

    task automatic t_travel();
        @(negedge clk); base_pair();
        step(); idle();
        for (int j = 1; j <= NST; j++) begin
            chk("R9 u stage", stg_u_valid, 1 << (j - 1));
            chk("R9 v stage", stg_v_valid, 1 << (j - 1));
            if (j == NST) begin
                chk("R9 wb u", wb_u_payload, 16'hA0A0);
                chk("R9 wb v", wb_v_payload, 16'hB1B1);
            end else step();
        end
        step();
        chk("R9 drained", stg_u_valid, 0);
    endtask

    task automatic t_bubble();
        @(negedge clk); base_pair(); s1_simple = 0;
        step(); idle(); step();
        chk("R9 bubble u", stg_u_valid, 4'b0010);
        chk("R9 bubble v", stg_v_valid, 4'b0000);
        repeat (NST) step();
    endtask

    task automatic t_stall();
        @(negedge clk); base_pair();
        step();
        stall = 1;
        expect_issue("R8 issue", 0, 0, 0);
        for (int j = 0; j < 3; j++) begin
            step();
            chk("R8 hold u", stg_u_valid, 4'b0001);
            chk("R8 hold v", stg_v_valid, 4'b0001);
        end
        idle(); step();
        chk("R8 resume", stg_u_valid, 4'b0010);
        chk("R8 resume", stg_v_valid, 4'b0010);
        repeat (NST) step();
    endtask

    task automatic t_reset_mid();
        @(negedge clk); base_pair();
        step(); step();
        rst_n = 0; idle();
        step();
        chk("R10 mid u", stg_u_valid, 0);
        chk("R10 mid v", stg_v_valid, 0);
        rst_n = 1;
    endtask

    initial begin
        t_reset();
        t_slot0_empty();
        t_slot1_empty();
        t_not_simple();
        t_shift();
        t_raw();
        t_waw();
        t_pair();
        @(negedge clk); idle(); repeat (NST + 1) step();
        t_travel();
        t_bubble();
        t_stall();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule